// File: doc/BRIEF.md
# Audio Serial Data Transmitter with Time-Division Slot Offset

This block turns a pair of parallel audio samples (left and right) into a serial bit stream on a single data line. Timing comes from two single-cycle strobes in the system clock domain. `bit_stb` marks each falling bit-clock edge, which is where a new bit slot begins. `frame_start`, raised together with `bit_stb`, marks slot 0 of a frame. Four framings are supported: left-justified, right-justified, I2S and DSP. Every framing sends the most significant bit first, and the sample width can be 16, 20, 24 or 32 bits.

A programmable slot offset moves both channel windows later in the frame. With the optional release of the line on empty slots, several transmitters can share one data wire in time-division multiplexed operation. New samples are taken only at a frame start. If no sample is offered at that point, the previous pair is sent again and an underrun flag is raised for that frame. A power-down input silences and releases the line at once.

Top module: `aud_tdm_tx`

## Requirements
- R1: Samples are right-aligned in the 32-bit input ports. `cfg_wsel` selects the width W: 0 gives 16, 1 gives 20, 2 gives 24 and 3 gives 32. Bit W-1 is sent first and bit 0 last, and input bits above W-1 are never sent.
- R2: With `cfg_fmt`=0 (left-justified), the left MSB occupies slot `cfg_offset` and the right MSB occupies slot `cfg_offset`+`cfg_half`. `cfg_half` gives the slots per channel half and must be at least W.
- R3: With `cfg_fmt`=2 (I2S), each channel window starts one slot later than in left-justified framing.
- R4: With `cfg_fmt`=1 (right-justified), the left LSB occupies slot `cfg_offset`+`cfg_half`-1 and the right LSB occupies slot `cfg_offset`+2*`cfg_half`-1.
- R5: With `cfg_fmt`=3 (DSP), the left MSB occupies slot `cfg_offset` and the right MSB follows immediately at slot `cfg_offset`+W.
- R6: A non-zero `cfg_offset` moves both channel windows later by that many slots in every framing.
- R7: In a slot that carries no sample bit, `dout` is 0. `dout_oe` is 0 when `cfg_tri_en`=1 and 1 when `cfg_tri_en`=0. In a data slot `dout_oe` is 1.
- R8: While `pwr_dn` is high, `dout` and `dout_oe` are both 0 from the next clock cycle on, with or without bit strobes.
- R9: `dout` and `dout_oe` change only in the cycle after a `bit_stb` cycle, or because of `pwr_dn`. After reset, `dout`, `dout_oe` and `underrun` are 0.
- R10: A sample pair is accepted when `in_valid` is high in a cycle with both `frame_start` and `bit_stb`. `smp_take` is high in exactly that cycle, the accepted pair is sent in the frame that begins there, and `underrun` is 0 for that frame.
- R11: If `in_valid` is low at a frame start, the previous pair is sent again and `underrun` is 1 from the next cycle until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe at each falling bit-clock edge |
| frame_start | input | 1 | With bit_stb, marks slot 0 of a frame |
| in_valid | input | 1 | A new sample pair is offered |
| in_left | input | 32 | Left sample, right-aligned |
| in_right | input | 32 | Right sample, right-aligned |
| smp_take | output | 1 | Offered pair accepted this cycle |
| cfg_fmt | input | 2 | Framing: 0 left-justified, 1 right-justified, 2 I2S, 3 DSP |
| cfg_wsel | input | 2 | Width code: 16, 20, 24 or 32 bits |
| cfg_offset | input | 8 | Slot offset of the data windows |
| cfg_half | input | 8 | Slots per channel half |
| cfg_tri_en | input | 1 | Release the line on slots that carry no data |
| pwr_dn | input | 1 | Power down: line released |
| dout | output | 1 | Serial data |
| dout_oe | output | 1 | Output enable for dout |
| underrun | output | 1 | No new sample at the last frame start |

## Verification
`dout` and `dout_oe` follow a `bit_stb` cycle by exactly one clock. `underrun` follows the frame-start strobe by one clock, and a rise of `pwr_dn` reaches the line one clock later. `smp_take` is valid in the strobe cycle itself. The bench drives inputs on the falling clock edge. It reads `smp_take` shortly after driving, and reads every registered result at the next falling edge, one register stage after the strobe. Extra idle cycles inserted at random between strobes check that the line holds steady when no strobe arrives.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_RJ  = 2'd1,
      FMT_I2S = 2'd2,
      FMT_DSP = 2'd3
   } fmt_e;

   localparam int CHANS = 2;

   function automatic logic [5:0] width_of(input logic [1:0] code);
      case (code)
         2'd0:    width_of = 6'd16;
         2'd1:    width_of = 6'd20;
         2'd2:    width_of = 6'd24;
         default: width_of = 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/aud_slot_ctr.sv
module aud_slot_ctr #(
   parameter int SLOT_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              frame_start,
   output logic [SLOT_W-1:0] slot_nxt
);
   localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

   logic [SLOT_W-1:0] slot_q;

   always_comb begin
      if (frame_start)
         slot_nxt = '0;
      else if (slot_q == SLOT_MAX)
         slot_nxt = SLOT_MAX;
      else
         slot_nxt = slot_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= SLOT_MAX;
      else if (bit_stb)
         slot_q <= slot_nxt;
   end
endmodule

// File: rtl/aud_sample_hold.sv
module aud_sample_hold #(
   parameter int SMP_W = 32,
   parameter int CHANS = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        take_frame,
   input  logic                        in_valid,
   input  logic [CHANS-1:0][SMP_W-1:0] din,
   output logic [CHANS-1:0][SMP_W-1:0] dnxt,
   output logic                        underrun
);
   logic load;
   assign load = take_frame & in_valid;

   for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
      logic [SMP_W-1:0] held;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            held <= '0;
         else if (load)
            held <= din[ch];
      end
      assign dnxt[ch] = load ? din[ch] : held;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         underrun <= 1'b0;
      else if (take_frame)
         underrun <= ~in_valid;
   end
endmodule

// File: rtl/aud_bit_pick.sv
module aud_bit_pick
   import aud_tx_pkg::*;
#(
   parameter int SMP_W  = 32,
   parameter int SLOT_W = 10,
   parameter int OFF_W  = 8,
   parameter int HALF_W = 8
) (
   input  logic [SLOT_W-1:0]           slot,
   input  logic [1:0]                  fmt,
   input  logic [1:0]                  wsel,
   input  logic [OFF_W-1:0]            off,
   input  logic [HALF_W-1:0]           half,
   input  logic [CHANS-1:0][SMP_W-1:0] smp,
   output logic                        has_data,
   output logic                        bit_val
);
   localparam int EW    = SLOT_W + 1;
   localparam int IDX_W = $clog2(SMP_W);

   logic [EW-1:0] w_e, off_e, half_e, slot_e;
   logic [CHANS-1:0][EW-1:0] start;
   logic [CHANS-1:0] hit, bitv;

   assign w_e    = EW'(width_of(wsel));
   assign off_e  = EW'(off);
   assign half_e = EW'(half);
   assign slot_e = EW'(slot);

   always_comb begin
      case (fmt_e'(fmt))
         FMT_LJ: begin
            start[0] = off_e;
            start[1] = off_e + half_e;
         end
         FMT_I2S: begin
            start[0] = off_e + EW'(1);
            start[1] = off_e + half_e + EW'(1);
         end
         FMT_RJ: begin
            start[0] = off_e + half_e - w_e;
            start[1] = off_e + (half_e << 1) - w_e;
         end
         default: begin
            start[0] = off_e;
            start[1] = off_e + w_e;
         end
      endcase
   end

   for (genvar ch = 0; ch < CHANS; ch++) begin : g_win
      logic [EW-1:0] pos, idx;
      assign pos      = slot_e - start[ch];
      assign idx      = w_e - EW'(1) - pos;
      assign hit[ch]  = (slot_e >= start[ch]) && (slot_e < start[ch] + w_e);
      assign bitv[ch] = smp[ch][idx[IDX_W-1:0]];
   end

   assign has_data = |hit;
   assign bit_val  = hit[0] ? bitv[0] : (hit[1] & bitv[1]);
endmodule

// File: rtl/aud_tdm_tx.sv
module aud_tdm_tx
   import aud_tx_pkg::*;
#(
   parameter int SMP_W  = 32,
   parameter int OFF_W  = 8,
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              frame_start,
   input  logic              in_valid,
   input  logic [SMP_W-1:0]  in_left,
   input  logic [SMP_W-1:0]  in_right,
   output logic              smp_take,
   input  logic [1:0]        cfg_fmt,
   input  logic [1:0]        cfg_wsel,
   input  logic [OFF_W-1:0]  cfg_offset,
   input  logic [HALF_W-1:0] cfg_half,
   input  logic              cfg_tri_en,
   input  logic              pwr_dn,
   output logic              dout,
   output logic              dout_oe,
   output logic              underrun
);
   localparam int SLOT_W = ((OFF_W > HALF_W) ? OFF_W : HALF_W) + 2;

   if (SMP_W != 32) begin : g_bad_smp
      $error("aud_tdm_tx: SMP_W must be 32 to carry every width code");
   end
   if (OFF_W < 1 || HALF_W < 6) begin : g_bad_cfg
      $error("aud_tdm_tx: HALF_W must hold at least 32 slots");
   end

   logic                        take_frame;
   logic [SLOT_W-1:0]           slot_nxt;
   logic [CHANS-1:0][SMP_W-1:0] din, dnxt;
   logic                        has_data, bit_val;

   assign take_frame = bit_stb & frame_start;
   assign smp_take   = take_frame & in_valid;
   assign din        = {in_right, in_left};

   aud_slot_ctr #(.SLOT_W(SLOT_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb     (bit_stb),
      .frame_start (frame_start),
      .slot_nxt    (slot_nxt)
   );

   aud_sample_hold #(.SMP_W(SMP_W), .CHANS(CHANS)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_frame (take_frame),
      .in_valid   (in_valid),
      .din        (din),
      .dnxt       (dnxt),
      .underrun   (underrun)
   );

   aud_bit_pick #(
      .SMP_W(SMP_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W), .HALF_W(HALF_W)
   ) u_pick (
      .slot     (slot_nxt),
      .fmt      (cfg_fmt),
      .wsel     (cfg_wsel),
      .off      (cfg_offset),
      .half     (cfg_half),
      .smp      (dnxt),
      .has_data (has_data),
      .bit_val  (bit_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else if (pwr_dn) begin
         dout    <= 1'b0;
         dout_oe <= 1'b0;
      end else if (bit_stb) begin
         dout    <= has_data & bit_val;
         dout_oe <= has_data | ~cfg_tri_en;
      end
   end
endmodule

// File: rtl/aud_tdm_tx_chk.sv
module aud_tdm_tx_chk #(
   parameter int SMP_W  = 32,
   parameter int OFF_W  = 8,
   parameter int HALF_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_stb,
   input logic              frame_start,
   input logic              in_valid,
   input logic [SMP_W-1:0]  in_left,
   input logic [SMP_W-1:0]  in_right,
   input logic              smp_take,
   input logic [1:0]        cfg_fmt,
   input logic [1:0]        cfg_wsel,
   input logic [OFF_W-1:0]  cfg_offset,
   input logic [HALF_W-1:0] cfg_half,
   input logic              cfg_tri_en,
   input logic              pwr_dn,
   input logic              dout,
   input logic              dout_oe,
   input logic              underrun
);
   AST_PWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!dout_oe && !dout)); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_stb && !pwr_dn) |=> ($stable(dout) && $stable(dout_oe))); // R9
   AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && frame_start && !in_valid) |=> underrun); // R11
   AST_UNDERRUN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && frame_start && in_valid) |=> !underrun); // R10
   AST_UNDERRUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bit_stb && frame_start) |=> $stable(underrun)); // R11
   AST_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !pwr_dn && !cfg_tri_en) |=> dout_oe); // R7
   AST_RELEASED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> !dout); // R7
endmodule

bind aud_tdm_tx aud_tdm_tx_chk #(.SMP_W(SMP_W), .OFF_W(OFF_W), .HALF_W(HALF_W)) u_chk (.*);

// File: tb/aud_tdm_tx_tb.sv
module aud_tdm_tx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_stb = 1'b0, frame_start = 1'b0, in_valid = 1'b0;
   logic [31:0] in_left = '0, in_right = '0;
   logic        smp_take;
   logic [1:0]  cfg_fmt = '0, cfg_wsel = '0;
   logic [7:0]  cfg_offset = '0, cfg_half = 8'd32;
   logic        cfg_tri_en = 1'b1, pwr_dn = 1'b0;
   logic        dout, dout_oe, underrun;

   int total = 0, bad = 0;
   bit done = 0;
   int slot_i = 0;
   logic [31:0] cur_l = '0, cur_r = '0;
   logic exp_ur = 1'b0;
   string tag_ovr = "";

   always #2 clk = ~clk;

   aud_tdm_tx u_dut (.*);

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int wid(input logic [1:0] c);
      return (c == 2'd0) ? 16 : (c == 2'd1) ? 20 : (c == 2'd2) ? 24 : 32;
   endfunction

   // expected {oe, dout} and whether the slot carries data
   function automatic logic [2:0] expect_slot(input int s);
      int w = wid(cfg_wsel);
      int o = cfg_offset;
      int h = cfg_half;
      int lft, rgt;
      case (cfg_fmt)
         2'd0: begin lft = o;         rgt = o + h;         end
         2'd1: begin lft = o + h - w; rgt = o + 2 * h - w; end
         2'd2: begin lft = o + 1;     rgt = o + h + 1;     end
         default: begin lft = o;      rgt = o + w;         end
      endcase
      if (s >= lft && s < lft + w) return {1'b1, 1'b1, cur_l[w - 1 - (s - lft)]};
      if (s >= rgt && s < rgt + w) return {1'b1, 1'b1, cur_r[w - 1 - (s - rgt)]};
      return {1'b0, ~cfg_tri_en, 1'b0};
   endfunction

   function automatic string data_tag();
      if (tag_ovr != "") return tag_ovr;
      if (cfg_offset != 0) return "R6";
      case (cfg_fmt)
         2'd0: return "R2";
         2'd1: return "R4";
         2'd2: return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic do_slot(input bit fs);
      logic [2:0] e;
      logic       d0, o0;
      @(negedge clk);
      bit_stb = 1'b1;
      frame_start = fs;
      #1;
      if (fs) begin
         chk(smp_take == in_valid, "R10", "smp_take at frame start", smp_take, in_valid);
         slot_i = 0;
         if (in_valid) begin
            cur_l = in_left;
            cur_r = in_right;
         end
         exp_ur = ~in_valid;
      end else begin
         slot_i++;
      end
      @(negedge clk);
      bit_stb = 1'b0;
      frame_start = 1'b0;
      e = expect_slot(slot_i);
      chk({dout_oe, dout} == e[1:0], e[2] ? data_tag() : "R7",
          $sformatf("slot %0d fmt %0d {oe,dout}", slot_i, cfg_fmt), {dout_oe, dout}, e[1:0]);
      if (fs) chk(underrun == exp_ur, exp_ur ? "R11" : "R10", "underrun", underrun, exp_ur);
      if ($urandom % 4 == 0) begin
         d0 = dout;
         o0 = dout_oe;
         @(negedge clk);
         chk(dout == d0 && dout_oe == o0, "R9", "line steady without strobe",
             {dout_oe, dout}, {o0, d0});
      end
   endtask

   task automatic run_frame(input bit vld);
      in_valid = vld;
      in_left  = $urandom;
      in_right = $urandom;
      do_slot(1'b1);
      in_valid = 1'b0;
      for (int i = 1; i < cfg_offset + 2 * cfg_half + 3; i++) do_slot(1'b0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd8117));
      repeat (3) @(negedge clk);
      chk(dout == 0 && dout_oe == 0 && underrun == 0, "R9", "reset state",
          {underrun, dout_oe, dout}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);

      // each framing, 16 bits, no offset
      for (int f = 0; f < 4; f++) begin
         cfg_fmt = f[1:0];
         run_frame(1'b1);
      end

      // R1: every width code, left-justified and DSP
      tag_ovr = "R1";
      for (int ws = 0; ws < 4; ws++) begin
         cfg_wsel = ws[1:0];
         cfg_fmt  = 2'd0;
         run_frame(1'b1);
         cfg_fmt  = 2'd3;
         run_frame(1'b1);
      end
      tag_ovr = "";

      // R6: large offset for TDM placement, DSP and I2S
      cfg_wsel = 2'd1;
      cfg_fmt = 2'd3; cfg_offset = 8'd200;
      run_frame(1'b1);
      cfg_fmt = 2'd2; cfg_offset = 8'd5;
      run_frame(1'b1);

      // R7: line driven low on empty slots
      cfg_tri_en = 1'b0; cfg_fmt = 2'd1; cfg_offset = 8'd3;
      run_frame(1'b1);
      cfg_tri_en = 1'b1;

      // R11 then R10: repeated sample, then recovery
      cfg_fmt = 2'd0; cfg_offset = 8'd0;
      run_frame(1'b0);
      run_frame(1'b0);
      run_frame(1'b1);

      // R8: power down mid-frame, with and without strobes
      cfg_tri_en = 1'b0;
      in_valid = 1'b1;
      in_left = 32'hFFFF_FFFF;
      do_slot(1'b1);
      for (int i = 0; i < 3; i++) do_slot(1'b0);
      @(negedge clk);
      pwr_dn = 1'b1;
      @(negedge clk);
      chk(dout == 0 && dout_oe == 0, "R8", "power down quiet", {dout_oe, dout}, 2'b00);
      bit_stb = 1'b1;
      @(negedge clk);
      bit_stb = 1'b0;
      chk(dout == 0 && dout_oe == 0, "R8", "power down with strobe", {dout_oe, dout}, 2'b00);
      pwr_dn = 1'b0;
      cfg_tri_en = 1'b1;

      // random configurations
      for (int k = 0; k < 24; k++) begin
         cfg_fmt    = 2'($urandom);
         cfg_wsel   = 2'($urandom);
         cfg_half   = 8'(wid(cfg_wsel) + $urandom % 40);
         cfg_offset = 8'($urandom % 64);
         cfg_tri_en = 1'($urandom);
         run_frame(($urandom % 5) != 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule